// File: doc/BRIEF.md
# Contended Dual-Port RAM with Collision Arbiter

This block is a synchronous true dual-port memory. It has 2048 words of 8 bits at the default size. It has two independent access sides, called left and right. Each side has an active-low select, a read/not-write strobe and an active-low output enable. Both sides can read or write any word in the same cycle. When both selected sides present one address, a collision arbiter picks an owner. The other side sees its active-low busy flag fall. A blocked write on the losing side is dropped. A blocked read holds its last captured data while the collision lasts.

The first side to settle on the address wins. A side has settled when it was selected at that same address in the previous cycle. When both sides arrive in the same cycle, a parameter names the winner. Ownership stays fixed until the collision ends. The collision ends when the addresses differ or when either side deselects.

A second build option turns the block into a follower device, for stacking two devices into a wider word. In this option the busy pins stay high and each side takes an active-low hold input from outside. A low hold input blocks that side's writes. Read data is registered. The read data bus is nonzero only while the side is selected, its output enable is low and it is reading.

Top module: `dpram_contend`

## Requirements
- R1: While reset is low, both busy outputs are high and the registered read data is zero. A side that is selected with output enable low and reading therefore shows 0.
- R2: A side writes `wdata` to `addr` at the clock edge when its select is low and `rd_wn` is low. A side reading with select low shows the word at `addr` on `rdata` in the cycle after the edge.
- R3: `rdata` is driven only when select = 0, output enable = 0 and `rd_wn` = 1. With any other combination of these three inputs, `rdata` is all zeros.
- R4: Both sides may read the same word in the same cycles, and both receive its stored value.
- R5: A collision means both sides are selected with equal addresses. In a collision, the side that was already selected at that address in the previous cycle wins. The other side sees its busy output low in the same cycle. Busy is never low on both sides at once.
- R6: When both sides start the collision in the same cycle, the left side wins if TIE_LEFT = 1 and the right side wins if TIE_LEFT = 0.
- R7: The winner keeps ownership for every cycle that the collision continues.
- R8: Busy returns high in the first cycle in which the addresses differ or either side is deselected.
- R9: With SLAVE = 0, a write by the side whose busy is low does not change memory.
- R10: A side reading under busy keeps the data it captured in its first busy cycle, even if the winner writes that word. Fresh data is captured once busy is released, or once the side's address, select or `rd_wn` changes.
- R11: With SLAVE = 1, both busy outputs stay high regardless of address matches. A low `hold_n` blocks that side's write, and a high `hold_n` lets it through.
- R12: Writes on both sides in the same cycle to different addresses both land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs_n | input | 1 | Left select, active low |
| l_rd_wn | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W (11) | Left word address |
| l_wdata | input | DATA_W (8) | Left write data |
| l_hold_n | input | 1 | Left external hold, active low (follower mode only) |
| l_rdata | output | DATA_W (8) | Left read data, zero when not driven |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_rd_wn | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W (11) | Right word address |
| r_wdata | input | DATA_W (8) | Right write data |
| r_hold_n | input | 1 | Right external hold, active low (follower mode only) |
| r_rdata | output | DATA_W (8) | Right read data, zero when not driven |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
The bench builds three copies with ADDR_W = 4 and DATA_W = 8, and all three share one stimulus:
- an arbitrating copy with TIE_LEFT = 1;
- an arbitrating copy with TIE_LEFT = 0;
- a follower copy with SLAVE = 1.

The 16-word depth makes it cheap to sweep every pair of left and right addresses under three arrival orders: left first, right first and both together. Each order is checked for busy polarity, ownership hold, release and same-word reads. Running both tie settings side by side checks each tie-break outcome against the other. Directed sequences cover dropped writes, frozen reads and hold-driven blocking in the follower copy.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Which side currently owns a contended address
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_L    = 0;
    localparam int SIDE_R    = 1;

endpackage

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int TIE_LEFT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SIDES-1:0] act,
    input  logic [ADDR_W-1:0]    addr_l,
    input  logic [ADDR_W-1:0]    addr_r,
    output logic [NUM_SIDES-1:0] lose
);

    typedef struct packed {
        owner_e                owner;
        logic [NUM_SIDES-1:0]  act;
        logic [ADDR_W-1:0]     a_l;
        logic [ADDR_W-1:0]     a_r;
    } arb_state_t;

    arb_state_t s_d, s_q;
    owner_e     owner_now;
    logic       hit;
    logic       settled_l;
    logic       settled_r;

    always_comb begin
        s_d       = s_q;
        hit       = act[SIDE_L] & act[SIDE_R] & (addr_l == addr_r);
        // a side has settled if it sat on the same address last cycle
        settled_l = s_q.act[SIDE_L] & act[SIDE_L] & (s_q.a_l == addr_l);
        settled_r = s_q.act[SIDE_R] & act[SIDE_R] & (s_q.a_r == addr_r);

        if (!rst_n || !hit) begin
            owner_now = OWN_NONE;
        end else if (s_q.owner != OWN_NONE) begin
            owner_now = s_q.owner;
        end else if (settled_l && !settled_r) begin
            owner_now = OWN_LEFT;
        end else if (settled_r && !settled_l) begin
            owner_now = OWN_RIGHT;
        end else begin
            owner_now = (TIE_LEFT != 0) ? OWN_LEFT : OWN_RIGHT;
        end

        s_d.owner = owner_now;
        s_d.act   = act;
        s_d.a_l   = addr_l;
        s_d.a_r   = addr_r;

        lose[SIDE_L] = (owner_now == OWN_RIGHT);
        lose[SIDE_R] = (owner_now == OWN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{owner: OWN_NONE, act: '0, a_l: '0, a_r: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_l,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wd_l,
    input  logic [DATA_W-1:0] wd_r,
    output logic [DATA_W-1:0] rd_l,
    output logic [DATA_W-1:0] rd_r
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Combinational read: a same-edge write is seen one cycle later
    assign rd_l = cells[addr_l];
    assign rd_r = cells[addr_r];

    always_ff @(posedge clk) begin
        if (we_l) cells[addr_l] <= wd_l;
        if (we_r) cells[addr_r] <= wd_r;
    end

endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              rd,
    input  logic              oe_n,
    input  logic              blk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_rd,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              was_blk;
        logic              was_rd;
        logic [ADDR_W-1:0] addr;
    } port_state_t;

    port_state_t s_d, s_q;
    logic        rd_now;
    logic        freeze;

    always_comb begin
        s_d    = s_q;
        rd_now = act & rd;
        // keep the captured word while a blocked read sits still
        freeze = rd_now & blk & s_q.was_blk & s_q.was_rd & (s_q.addr == addr);

        if (rd_now && !freeze) begin
            s_d.rdata = mem_rd;
        end
        s_d.was_blk = blk;
        s_d.was_rd  = rd_now;
        s_d.addr    = addr;

        rdata = (act && !oe_n && rd) ? s_q.rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dpram_contend.sv
module dpram_contend
    import dpram_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int SLAVE    = 0,
    parameter int TIE_LEFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_rd_wn,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_hold_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n,
    input  logic              r_cs_n,
    input  logic              r_rd_wn,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_hold_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n
);

    localparam logic FOLLOWER = (SLAVE != 0);

    logic [NUM_SIDES-1:0] act;
    logic [NUM_SIDES-1:0] rdm;
    logic [NUM_SIDES-1:0] oen;
    logic [NUM_SIDES-1:0] blk;
    logic [NUM_SIDES-1:0] lose;
    logic [NUM_SIDES-1:0] we;
    logic [NUM_SIDES-1:0] busy_v;
    logic [ADDR_W-1:0]    addr_v [NUM_SIDES];
    logic [DATA_W-1:0]    mrd    [NUM_SIDES];
    logic [DATA_W-1:0]    rdo    [NUM_SIDES];

    always_comb begin
        act            = {~r_cs_n, ~l_cs_n};
        rdm            = {r_rd_wn, l_rd_wn};
        oen            = {r_oe_n, l_oe_n};
        addr_v[SIDE_L] = l_addr;
        addr_v[SIDE_R] = r_addr;

        // follower: the external hold inputs block writes, no flags out
        blk    = FOLLOWER ? ~{r_hold_n, l_hold_n} : lose;
        busy_v = FOLLOWER ? '0 : lose;
        we     = act & ~rdm & ~blk;
    end

    assign l_busy_n = ~busy_v[SIDE_L];
    assign r_busy_n = ~busy_v[SIDE_R];

    dpram_arb #(
        .ADDR_W   (ADDR_W),
        .TIE_LEFT (TIE_LEFT)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .addr_l (l_addr),
        .addr_r (r_addr),
        .lose   (lose)
    );

    dpram_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk    (clk),
        .we_l   (we[SIDE_L]),
        .we_r   (we[SIDE_R]),
        .addr_l (l_addr),
        .addr_r (r_addr),
        .wd_l   (l_wdata),
        .wd_r   (r_wdata),
        .rd_l   (mrd[SIDE_L]),
        .rd_r   (mrd[SIDE_R])
    );

    for (genvar i = 0; i < NUM_SIDES; i++) begin : g_side
        dpram_port #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .act    (act[i]),
            .rd     (rdm[i]),
            .oe_n   (oen[i]),
            .blk    (blk[i]),
            .addr   (addr_v[i]),
            .mem_rd (mrd[i]),
            .rdata  (rdo[i])
        );
    end

    assign l_rdata = rdo[SIDE_L];
    assign r_rdata = rdo[SIDE_R];

endmodule

// File: rtl/dpram_contend_chk.sv
module dpram_contend_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_cs_n,
    input logic              l_rd_wn,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy_n,
    input logic              r_cs_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n
);

    // R5: never both sides flagged
    assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    // R8: a flag requires a live collision
    assert_busy_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n || !r_busy_n) |-> (!l_cs_n && !r_cs_n && (l_addr == r_addr)));

    // R7: the right side stays the loser while the collision continues
    assert_owner_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!r_busy_n) && !l_cs_n && !r_cs_n && (l_addr == r_addr)) |-> !r_busy_n);

    // R10: two blocked read cycles in a row at one address freeze the next output
    assert_read_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!l_busy_n && !l_cs_n && l_rd_wn) && !l_busy_n && !l_cs_n && l_rd_wn
         && (l_addr == $past(l_addr)) && !l_oe_n)
        |=> (l_cs_n || l_oe_n || !l_rd_wn || (l_rdata == $past(l_rdata))));

endmodule

bind dpram_contend dpram_contend_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_cs_n   (l_cs_n),
    .l_rd_wn  (l_rd_wn),
    .l_oe_n   (l_oe_n),
    .l_addr   (l_addr),
    .l_rdata  (l_rdata),
    .l_busy_n (l_busy_n),
    .r_cs_n   (r_cs_n),
    .r_addr   (r_addr),
    .r_busy_n (r_busy_n)
);

// File: tb/sim_dpram_contend.sv
module sim_dpram_contend;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          l_cs_n = 1'b1, l_rd_wn = 1'b1, l_oe_n = 1'b1, l_hold_n = 1'b1;
    logic          r_cs_n = 1'b1, r_rd_wn = 1'b1, r_oe_n = 1'b1, r_hold_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wd = '0, r_wd = '0;

    logic [DW-1:0] lrd [3];
    logic [DW-1:0] rrd [3];
    logic          lbz [3];
    logic          rbz [3];

    logic [DW-1:0] em [N];
    logic [DW-1:0] es [N];

    int n_chk = 0;
    int n_bad = 0;

    dpram_contend #(.ADDR_W(AW), .DATA_W(DW), .SLAVE(0), .TIE_LEFT(1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rd_wn(l_rd_wn), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wd), .l_hold_n(l_hold_n), .l_rdata(lrd[0]), .l_busy_n(lbz[0]),
        .r_cs_n(r_cs_n), .r_rd_wn(r_rd_wn), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wd), .r_hold_n(r_hold_n), .r_rdata(rrd[0]), .r_busy_n(rbz[0]));

    dpram_contend #(.ADDR_W(AW), .DATA_W(DW), .SLAVE(1), .TIE_LEFT(1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rd_wn(l_rd_wn), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wd), .l_hold_n(l_hold_n), .l_rdata(lrd[1]), .l_busy_n(lbz[1]),
        .r_cs_n(r_cs_n), .r_rd_wn(r_rd_wn), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wd), .r_hold_n(r_hold_n), .r_rdata(rrd[1]), .r_busy_n(rbz[1]));

    dpram_contend #(.ADDR_W(AW), .DATA_W(DW), .SLAVE(0), .TIE_LEFT(0)) u2 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rd_wn(l_rd_wn), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wd), .l_hold_n(l_hold_n), .l_rdata(lrd[2]), .l_busy_n(lbz[2]),
        .r_cs_n(r_cs_n), .r_rd_wn(r_rd_wn), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wd), .r_hold_n(r_hold_n), .r_rdata(rrd[2]), .r_busy_n(rbz[2]));

    function automatic logic [DW-1:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic idle();
        l_cs_n = 1'b1; l_rd_wn = 1'b1; l_oe_n = 1'b1;
        r_cs_n = 1'b1; r_rd_wn = 1'b1; r_oe_n = 1'b1;
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, with a would-be collision on the inputs
        l_cs_n = 1'b0; l_oe_n = 1'b0; r_cs_n = 1'b0; r_oe_n = 1'b0;
        repeat (3) nxt();
        for (int i = 0; i < 3; i++) begin
            chk("R1 left rdata in reset", lrd[i], 0);
            chk("R1 right rdata in reset", rrd[i], 0);
            chk("R1 left busy in reset", lbz[i], 1);
            chk("R1 right busy in reset", rbz[i], 1);
        end
        rst_n = 1'b1;
        idle();
        nxt();

        // R12 / R2: dual writes to distinct words
        for (int a = 0; a < N / 2; a++) begin
            l_cs_n = 1'b0; l_rd_wn = 1'b0; l_addr = AW'(a);         l_wd = pat(a);
            r_cs_n = 1'b0; r_rd_wn = 1'b0; r_addr = AW'(a + N / 2); r_wd = pat(a + N / 2);
            em[a] = pat(a); em[a + N / 2] = pat(a + N / 2);
            es[a] = pat(a); es[a + N / 2] = pat(a + N / 2);
            nxt();
        end
        idle();
        nxt();
        for (int a = 0; a < N; a++) begin
            l_cs_n = 1'b0; l_oe_n = 1'b0; l_addr = AW'(a);
            r_cs_n = 1'b0; r_oe_n = 1'b0; r_addr = AW'(N - 1 - a);
            nxt();
            chk("R2 R12 left read u0", lrd[0], em[a]);
            chk("R2 R12 right read u0", rrd[0], em[N - 1 - a]);
            chk("R2 left read u1", lrd[1], es[a]);
            chk("R2 right read u2", rrd[2], em[N - 1 - a]);
        end
        idle();
        nxt();

        // R3: output gating over all control combinations
        l_cs_n = 1'b0; l_oe_n = 1'b0; l_addr = 4'd5; l_wd = em[5];
        nxt();
        for (int c = 0; c < 8; c++) begin
            {l_cs_n, l_oe_n, l_rd_wn} = 3'(c);
            #1;
            chk("R3 rdata gating", lrd[0], (c == 1) ? 16'(em[5]) : 16'd0);
            nxt();
        end
        idle();
        nxt();

        // R4-R8: every address pair under three arrival orders
        for (int la = 0; la < N; la++) begin
            for (int ra = 0; ra < N; ra++) begin
                for (int m = 0; m < 3; m++) begin
                    logic hit;
                    logic u0_left_wins;
                    logic u2_left_wins;
                    hit          = (la == ra);
                    u0_left_wins = (m != 1);
                    u2_left_wins = (m == 0);
                    l_addr = AW'(la); r_addr = AW'(ra);
                    l_oe_n = 1'b0;    r_oe_n = 1'b0;
                    l_cs_n = (m == 1); r_cs_n = (m == 0);
                    nxt();
                    l_cs_n = 1'b0; r_cs_n = 1'b0;
                    #1;
                    chk("R5 R6 left busy u0", lbz[0], !(hit && !u0_left_wins));
                    chk("R5 R6 right busy u0", rbz[0], !(hit && u0_left_wins));
                    chk("R5 R6 left busy u2", lbz[2], !(hit && !u2_left_wins));
                    chk("R5 R6 right busy u2", rbz[2], !(hit && u2_left_wins));
                    chk("R11 follower busy", {lbz[1], rbz[1]}, 2'b11);
                    nxt();
                    chk("R7 right busy held u0", rbz[0], !(hit && u0_left_wins));
                    chk("R4 left read u0", lrd[0], em[la]);
                    chk("R4 right read u0", rrd[0], em[ra]);
                    if (u0_left_wins) l_cs_n = 1'b1;
                    else              r_cs_n = 1'b1;
                    #1;
                    chk("R8 release on deselect", {lbz[0], rbz[0]}, 2'b11);
                    nxt();
                    idle();
                    nxt();
                end
            end
        end

        // R8: address change releases, return re-flags the newcomer
        l_cs_n = 1'b0; l_addr = 4'd3;
        nxt();
        r_cs_n = 1'b0; r_addr = 4'd3;
        #1;
        chk("R8 flagged before move", rbz[0], 0);
        nxt();
        r_addr = 4'd4;
        #1;
        chk("R8 released on mismatch", {lbz[0], rbz[0]}, 2'b11);
        nxt();
        r_addr = 4'd3;
        #1;
        chk("R8 newcomer flagged again", rbz[0], 0);
        nxt();
        idle();
        nxt();

        // R9: the loser's write is dropped in arbitrating copies
        l_cs_n = 1'b0; l_addr = 4'd6;
        nxt();
        r_cs_n = 1'b0; r_rd_wn = 1'b0; r_addr = 4'd6; r_wd = 8'hAA;
        #1;
        chk("R9 writer flagged", rbz[0], 0);
        es[6] = 8'hAA;
        nxt();
        idle();
        nxt();
        l_cs_n = 1'b0; l_oe_n = 1'b0; l_addr = 4'd6;
        nxt();
        chk("R9 word kept u0", lrd[0], em[6]);
        chk("R9 word kept u2", lrd[2], em[6]);
        chk("R11 follower write lands", lrd[1], es[6]);
        idle();
        nxt();

        // R10: frozen read while the winner writes, refresh after release
        r_cs_n = 1'b0; r_oe_n = 1'b0; r_addr = 4'd9;
        nxt();
        l_cs_n = 1'b0; l_oe_n = 1'b0; l_addr = 4'd9;
        #1;
        chk("R10 reader flagged", lbz[0], 0);
        nxt();
        r_rd_wn = 1'b0; r_wd = 8'h5C;
        nxt();
        chk("R10 frozen after write", lrd[0], em[9]);
        nxt();
        chk("R10 still frozen", lrd[0], em[9]);
        chk("R10 still frozen u2", lrd[2], em[9]);
        r_cs_n = 1'b1; r_rd_wn = 1'b1;
        #1;
        chk("R10 released", lbz[0], 1);
        nxt();
        em[9] = 8'h5C; es[9] = 8'h5C;
        chk("R10 refreshed", lrd[0], em[9]);
        idle();
        nxt();

        // R11: hold inputs gate follower writes
        l_cs_n = 1'b0; l_rd_wn = 1'b0; l_addr = 4'd2;  l_wd = 8'h33; l_hold_n = 1'b0;
        r_cs_n = 1'b0; r_rd_wn = 1'b0; r_addr = 4'd12; r_wd = 8'h44; r_hold_n = 1'b1;
        em[2] = 8'h33; em[12] = 8'h44; es[12] = 8'h44;
        nxt();
        l_hold_n = 1'b1;
        idle();
        l_cs_n = 1'b0; l_oe_n = 1'b0; r_cs_n = 1'b0; r_oe_n = 1'b0;
        nxt();
        chk("R11 left held write blocked", lrd[1], es[2]);
        chk("R11 right open write lands", rrd[1], es[12]);
        chk("R11 arbitrating copy ignores hold", lrd[0], em[2]);
        l_rd_wn = 1'b0; l_wd = 8'h66;
        r_rd_wn = 1'b0; r_wd = 8'h77; r_hold_n = 1'b0;
        em[2] = 8'h66; em[12] = 8'h77; es[2] = 8'h66;
        nxt();
        r_hold_n = 1'b1;
        l_rd_wn = 1'b1; r_rd_wn = 1'b1;
        nxt();
        chk("R11 left open write lands", lrd[1], es[2]);
        chk("R11 right held write blocked", rrd[1], es[12]);
        chk("R11 right arbitrating write", rrd[2], em[12]);
        idle();
        nxt();

        summary();
        $finish;
    end

endmodule